// File: doc/BRIEF.md
# Nibble-Serial 8-bit ALU

This block is a small arithmetic and logic unit. It takes two 8-bit operands, A and B, and keeps an 8-bit result register C and a one-bit carry flag. Addition is deliberately split into two operations, each covering one 4-bit half. The low-half add and the high-half add each write only their own half of C. They are linked only through the carry flag, which persists between operations. A full 8-bit sum is therefore a carry clear, then a low-half add, then a high-half add.

Besides addition, the unit performs bitwise AND, OR, XOR and NOT into C, and single-bit left and right shifts that push the bit shifted out into the carry. It also has two operations that clear or set the carry flag directly. A surrounding sequencer drives an operation code and an execute strobe. Nothing changes on a clock edge where the strobe is low. The unit also provides a flag that is high when C is zero, which the sequencer can use for conditional branching.

Top module: `nsalu_core`

## Requirements
- R1: While rst_n is low, and after reset is released, c_out is 0x00, carry_out is 0 and c_zero is 1.
- R2: Opcode 4'd0 (low-half add) with exec_en high sets C[3:0] to the low 4 bits of A[3:0]+B[3:0]+carry, sets carry to the fifth bit of that sum, and leaves C[7:4] unchanged.
- R3: Opcode 4'd1 (high-half add) sets C[7:4] to the low 4 bits of A[7:4]+B[7:4]+carry, sets carry to the fifth bit of that sum, and leaves C[3:0] unchanged.
- R4: Opcodes 4'd2, 4'd3 and 4'd4 write A AND B, A OR B and A XOR B into C, and leave carry unchanged.
- R5: Opcode 4'd5 writes the bitwise inverse of A into C and leaves carry unchanged.
- R6: Opcode 4'd8 (shift left) writes {A[6:0],1'b0} into C and A[7] into carry.
- R7: Opcode 4'd9 (shift right) writes {1'b0,A[7:1]} into C and A[0] into carry.
- R8: Opcode 4'd6 clears carry and opcode 4'd7 sets carry. Both leave C unchanged.
- R9: On an edge where exec_en is low, C and carry hold their values whatever op_sel, a_in and b_in are.
- R10: Opcodes 4'd10 to 4'd15 change neither C nor carry, even with exec_en high.
- R11: c_zero is 1 exactly when c_out is 0x00. It follows C without extra delay.
- R12: A carry clear, then a low-half add, then a high-half add leaves C equal to (A+B) mod 256 and carry equal to bit 8 of A+B.
- R13: Results appear on c_out and carry_out right after the rising clock edge at which exec_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| exec_en | input | 1 | Execute strobe; the operation takes effect at this edge when high |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| c_out | output | 8 | Result register C |
| carry_out | output | 1 | Carry flag |
| c_zero | output | 1 | High when C is zero |

## Verification
The hardest state to reach is a high-half add whose carry-in was produced by an earlier low-half add, while the low half of C still holds that earlier result. The carry link between the halves only shows when the two operations arrive in sequence with the right operand values. The stimulus therefore issues chained add sequences whose low halves overflow (0x0F+0x01, 0xFF+0x01, 0x88+0x88). It also runs a high-half add with carry already forced to 1, and it checks both halves of C after each step.

// File: rtl/nsalu_pkg.sv
package nsalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD_LO = 4'd0,
    OP_ADD_HI = 4'd1,
    OP_AND    = 4'd2,
    OP_OR     = 4'd3,
    OP_XOR    = 4'd4,
    OP_NOT    = 4'd5,
    OP_CY_CLR = 4'd6,
    OP_CY_SET = 4'd7,
    OP_SHL    = 4'd8,
    OP_SHR    = 4'd9
  } alu_op_e;
endpackage

// File: rtl/nsalu_nibble_adder.sv
module nsalu_nibble_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  function automatic logic [W:0] lane_add(input logic [W-1:0] p, input logic [W-1:0] q,
                                          input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  logic [W:0] full;
  assign full = lane_add(x, y, cin);
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/nsalu_logic.sv
module nsalu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res
);
  import nsalu_pkg::*;
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end
endmodule

// File: rtl/nsalu_shift.sv
module nsalu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         go_left,
  output logic [W-1:0] res,
  output logic         spill
);
  assign res   = go_left ? {a[W-2:0], 1'b0} : {1'b0, a[W-1:1]};
  assign spill = go_left ? a[W-1] : a[0];
endmodule

// File: rtl/nsalu_core.sv
module nsalu_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_sel,
  input  logic              exec_en,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] c_out,
  output logic              carry_out,
  output logic              c_zero
);
  import nsalu_pkg::*;

  localparam int NIB_W = DATA_W / 2;
  localparam int LANES = 2;

  logic [DATA_W-1:0] c_q, c_d;
  logic              cy_q, cy_d;

  logic [LANES-1:0][NIB_W-1:0] lane_sum;
  logic [LANES-1:0]            lane_cout;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      nsalu_nibble_adder #(.W(NIB_W)) u_add (
        .x   (a_in[g*NIB_W +: NIB_W]),
        .y   (b_in[g*NIB_W +: NIB_W]),
        .cin (cy_q),
        .sum (lane_sum[g]),
        .cout(lane_cout[g])
      );
    end
  endgenerate

  logic [DATA_W-1:0] logic_res;
  nsalu_logic #(.W(DATA_W)) u_logic (
    .a  (a_in),
    .b  (b_in),
    .op (op_sel),
    .res(logic_res)
  );

  logic [DATA_W-1:0] shift_res;
  logic              shift_spill;
  nsalu_shift #(.W(DATA_W)) u_shift (
    .a      (a_in),
    .go_left(op_sel == OP_SHL),
    .res    (shift_res),
    .spill  (shift_spill)
  );

  // named events for the checks
  logic fire_lo, fire_hi, fire_logic, fire_shl, fire_shr, fire_clr, fire_set, fire_undef;
  assign fire_lo    = exec_en && (op_sel == OP_ADD_LO);
  assign fire_hi    = exec_en && (op_sel == OP_ADD_HI);
  assign fire_logic = exec_en && (op_sel inside {OP_AND, OP_OR, OP_XOR, OP_NOT});
  assign fire_shl   = exec_en && (op_sel == OP_SHL);
  assign fire_shr   = exec_en && (op_sel == OP_SHR);
  assign fire_clr   = exec_en && (op_sel == OP_CY_CLR);
  assign fire_set   = exec_en && (op_sel == OP_CY_SET);
  assign fire_undef = exec_en && (op_sel > OP_SHR);

  always_comb begin
    c_d  = c_q;
    cy_d = cy_q;
    unique case (op_sel)
      OP_ADD_LO: begin c_d[NIB_W-1:0] = lane_sum[0]; cy_d = lane_cout[0]; end
      OP_ADD_HI: begin c_d[DATA_W-1:NIB_W] = lane_sum[1]; cy_d = lane_cout[1]; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: c_d = logic_res;
      OP_CY_CLR: cy_d = 1'b0;
      OP_CY_SET: cy_d = 1'b1;
      OP_SHL, OP_SHR: begin c_d = shift_res; cy_d = shift_spill; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q  <= '0;
      cy_q <= 1'b0;
    end else if (exec_en) begin
      c_q  <= c_d;
      cy_q <= cy_d;
    end
  end

  assign c_out     = c_q;
  assign carry_out = cy_q;
  assign c_zero    = (c_q == '0);

  // R2
  lo_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_lo |=> c_out[DATA_W-1:NIB_W] == $past(c_out[DATA_W-1:NIB_W]));
  // R3
  hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_hi |=> c_out[NIB_W-1:0] == $past(c_out[NIB_W-1:0]));
  // R4
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_logic |=> carry_out == $past(carry_out));
  // R6
  shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_shl |=> carry_out == $past(a_in[DATA_W-1]));
  // R7
  shr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_shr |=> carry_out == $past(a_in[0]));
  // R8
  carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_set |=> carry_out && $stable(c_out));
  // R8
  carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_clr |=> !carry_out && $stable(c_out));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(c_out) && $stable(carry_out));
  // R10
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_undef |=> $stable(c_out) && $stable(carry_out));
endmodule

// File: tb/nsalu_core_test.sv
`timescale 1ns/1ps
module nsalu_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic       exec_en = 1'b0;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] c_out;
  logic       carry_out, c_zero;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_c = 8'h00;
  logic       m_cy = 1'b0;

  always #4 clk = ~clk;

  nsalu_core uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .exec_en(exec_en),
    .a_in(a_in), .b_in(b_in), .c_out(c_out), .carry_out(carry_out), .c_zero(c_zero)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " C"}, c_out, m_c);
    chk({req, " carry"}, carry_out, m_cy);
    chk({req, " zero"}, c_zero, (m_c == 0) ? 1 : 0);
  endtask

  // independent model: integer arithmetic per opcode
  task automatic model(input int op, input int a, input int b);
    int s;
    case (op)
      0: begin s = (a % 16) + (b % 16) + m_cy; m_c = (m_c & 8'hF0) | 8'(s % 16); m_cy = (s >= 16); end
      1: begin s = (a / 16) + (b / 16) + m_cy; m_c = (m_c & 8'h0F) | 8'((s % 16) * 16); m_cy = (s >= 16); end
      2: m_c = 8'(a & b);
      3: m_c = 8'(a | b);
      4: m_c = 8'(a ^ b);
      5: m_c = 8'(255 - a);
      6: m_cy = 1'b0;
      7: m_cy = 1'b1;
      8: begin m_cy = (a >= 128); m_c = 8'((a * 2) % 256); end
      9: begin m_cy = a[0]; m_c = 8'(a / 2); end
      default: ;
    endcase
  endtask

  task automatic do_op(input int op, input int a, input int b);
    @(negedge clk);
    op_sel = 4'(op); a_in = 8'(a); b_in = 8'(b); exec_en = 1'b1;
    @(posedge clk); #1;
    model(op, a, b);
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic t_reset();
    #1; chk_all("R1 during reset");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; chk_all("R1 after release");
  endtask

  task automatic t_lo_add();
    do_op(7, 0, 0);
    do_op(2, 8'hA0, 8'hFF);            // C = A0
    do_op(0, 8'h09, 8'h08);            // 9+8+1 = 18 -> 2, carry
    chk_all("R2 low add carry in and out");
    chk("R2 high half kept", c_out[7:4], 4'hA);
    do_op(0, 8'h03, 8'h04);            // 3+4+1 = 8
    chk_all("R2 low add no carry");
  endtask

  task automatic t_hi_add();
    do_op(2, 8'h05, 8'h0F);            // C = 05
    do_op(7, 0, 0);
    do_op(1, 8'hF0, 8'h00);            // F+0+1 -> 0, carry
    chk_all("R3 high add with carry");
    chk("R3 low half kept", c_out[3:0], 4'h5);
  endtask

  task automatic t_logic();
    do_op(7, 0, 0);
    do_op(2, 8'hCA, 8'h3F); chk_all("R4 AND");
    do_op(3, 8'hC0, 8'h0A); chk_all("R4 OR");
    do_op(6, 0, 0);
    do_op(4, 8'hFF, 8'h5A); chk_all("R4 XOR");
    do_op(5, 8'h3C, 8'h00); chk_all("R5 NOT");
  endtask

  task automatic t_shift();
    do_op(8, 8'h81, 0); chk_all("R6 shift left msb 1");
    do_op(8, 8'h40, 0); chk_all("R6 shift left msb 0");
    do_op(9, 8'h03, 0); chk_all("R7 shift right lsb 1");
    do_op(9, 8'hFE, 0); chk_all("R7 shift right lsb 0");
  endtask

  task automatic t_carry();
    do_op(3, 8'h77, 0);
    do_op(7, 8'h12, 8'h34); chk_all("R8 set carry C kept");
    do_op(6, 8'h56, 8'h78); chk_all("R8 clear carry C kept");
  endtask

  task automatic t_hold();
    do_op(3, 8'h6B, 0);
    @(negedge clk);
    op_sel = 4'd5; a_in = 8'h00; b_in = 8'hFF; exec_en = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk_all("R9 idle hold");
  endtask

  task automatic t_undef();
    do_op(7, 0, 0);
    do_op(3, 8'h2D, 0);
    for (int k = 10; k < 16; k++) begin
      do_op(k, 8'hFF, 8'hFF);
      chk_all("R10 unused opcode");
    end
  endtask

  task automatic t_chain(input int a, input int b);
    do_op(6, 0, 0);
    do_op(0, a, b);
    do_op(1, a, b);
    chk("R12 chained sum", c_out, (a + b) % 256);
    chk("R12 chained carry", carry_out, (a + b) / 256);
  endtask

  task automatic t_zero();
    do_op(4, 8'h5A, 8'h5A); chk("R11 zero high", c_zero, 1); chk_all("R11 zero");
    do_op(3, 8'h01, 8'h00); chk("R11 zero low", c_zero, 0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    op_sel = 4'd3; a_in = 8'hE7; b_in = 8'h00; exec_en = 1'b1;
    #2; chk("R13 no change before edge", c_out, m_c);
    @(posedge clk); #1;
    model(3, 8'hE7, 0);
    chk("R13 result after edge", c_out, 8'hE7);
    @(negedge clk); exec_en = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_lo_add();
    t_hi_add();
    t_logic();
    t_shift();
    t_carry();
    t_hold();
    t_undef();
    t_chain(8'h0F, 8'h01);
    t_chain(8'hFF, 8'h01);
    t_chain(8'h88, 8'h88);
    t_chain(8'h12, 8'h34);
    t_zero();
    t_timing();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule